// File: doc/BRIEF.md
# Speed Error Lock Detector and Limiter

This block sits between a speed-error measurement stage and a digital loop filter in a motor speed control path. Each time a tachometer edge is measured, a signed 16-bit error sample arrives with a valid strobe. A zero error means the speed is correct. A negative error means the motor is too fast, and a positive error means it is too slow. The block does two things with each sample, using one signed window set by an upper bound register and a lower bound register.

First, the window is the lock-detection range. A programmable run of consecutive in-range samples raises a lock flag, which enables the phase-loop filter downstream. Second, the window is the saturation limit applied to the error word sent to the filter. Software sets the bounds, the enables and the hit count through a word-wide register port.

The error can be forwarded on every sample, or held in the error register until software fires a transfer trigger. Reset, a standby request and a module-stop request each clear the block.

Top module: `spd_lock_limiter`

## Requirements
- R1: While reset, `standby_i` or `mstop_i` is active, the block clears to its reset state, and a clear request takes priority over every other input. In that state the error register is 0x0000, the upper bound is 0x7FFF, the lower bound is 0x8000, the control register is zero, the hit count select is 00, `lock_o` is 0 and `flt_vld_o` is 0.
- R2: A sample strobe (`err_vld_i`) loads `err_i` into the error register, and this takes priority over a bus write to that register in the same cycle. A word write to address 0 also loads the error register. Address 0 reads back the error register.
- R3: A register write takes effect only when `reg_be_i` is 2'b11. Any other byte-enable pattern leaves every register unchanged.
- R4: The upper bound register (address 1) and the lower bound register (address 2) are write-only, and reading either one returns 0x0000.
- R5: With the limiter enabled (control bit 1), an error greater than the upper bound (signed compare) leaves the block as the upper bound. An error less than the lower bound leaves as the lower bound. The upper test is applied first. With the limiter off, the error passes through unchanged.
- R6: With auto transfer enabled (control bit 2), `flt_vld_o` is high for exactly the one cycle after each sample strobe, and `flt_err_o` then holds the sample after limiting. With auto transfer off, a sample produces no output strobe.
- R7: A word write to the control register (address 3) with bit 7 set produces a one-cycle `flt_vld_o` on the next cycle. In that cycle, `flt_err_o` holds the error register, limited with the limiter setting that was in force before the write. If a sample with auto transfer is present in the same cycle, the sample wins. Bit 7 reads back as 0.
- R8: With lock detection enabled (control bit 0), the hit count select (control bits 4:3) sets how many consecutive in-range samples are needed: 00, 01, 10 and 11 require 1, 2, 4 and 8 samples. A sample is in range when lower ≤ error ≤ upper, using a signed compare. `lock_o` rises one cycle after the sample that completes the run, and it stays high while further samples remain in range.
- R9: Three events drop `lock_o` to 0 and restart the count from the selected number: an out-of-range sample, lock detection being disabled, and any word write to the control register.
- R10: The control register reads back bits 4:0 as written: bit 0 lock enable, bit 1 limiter enable, bit 2 auto transfer, and bits 4:3 hit count select. All other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby clear request |
| mstop_i | input | 1 | Module-stop clear request |
| err_vld_i | input | 1 | Error sample strobe |
| err_i | input | 16 | Signed error sample |
| reg_wr_i | input | 1 | Register write strobe |
| reg_be_i | input | 2 | Byte enables; only 2'b11 writes |
| reg_addr_i | input | 2 | Register address: 0 error, 1 upper, 2 lower, 3 control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` (combinational) |
| flt_err_o | output | 16 | Limited error word to the filter |
| flt_vld_o | output | 1 | Filter data strobe |
| lock_o | output | 1 | Speed lock flag / phase filter enable |

## Verification
The hardest state to reach from the ports is a lock run of the longest length, 8 hits, that is then broken or restarted at an exact point. Examples are a control write landing in the same cycle as the completing sample, or a bound moved so that the next sample lands just outside. Purely random samples seldom give eight consecutive hits. To get there, the random phase draws bounds and errors from narrow, overlapping ranges centred near the window edges, so that in-range runs are common. Directed cases also place samples exactly on both bounds, one count past them, and at the full-scale extremes.

// File: rtl/spd_lock_pkg.sv
package spd_lock_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [1:0] {
      ADR_ERR   = 2'd0,
      ADR_UPPER = 2'd1,
      ADR_LOWER = 2'd2,
      ADR_CTRL  = 2'd3
   } reg_adr_e;

   localparam int CTL_LOCK_EN = 0;
   localparam int CTL_LIM_EN  = 1;
   localparam int CTL_AUTO    = 2;
   localparam int CTL_SEL_LSB = 3;
   localparam int CTL_TRIG    = 7;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             auto_x;
      logic             lim_en;
      logic             lock_en;
   } ctrl_t;
endpackage

// File: rtl/spd_lock_regs.sv
module spd_lock_regs
   import spd_lock_pkg::*;
#(
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             smp_vld_i,
   input  logic [ERR_W-1:0] smp_err_i,
   input  logic             wr_i,
   input  logic [ERR_W/8-1:0] be_i,
   input  logic [1:0]       addr_i,
   input  logic [ERR_W-1:0] wdata_i,
   output logic [ERR_W-1:0] rdata_o,
   output logic [ERR_W-1:0] err_q_o,
   output logic [ERR_W-1:0] upper_q_o,
   output logic [ERR_W-1:0] lower_q_o,
   output ctrl_t            ctrl_q_o,
   output logic             ctrl_wr_o,
   output logic             trig_o
);
   localparam logic [ERR_W-1:0] UPPER_RST = {1'b0, {(ERR_W-1){1'b1}}};
   localparam logic [ERR_W-1:0] LOWER_RST = {1'b1, {(ERR_W-1){1'b0}}};
   localparam int CTL_W = $bits(ctrl_t);

   logic word_wr;
   logic [ERR_W-1:0] err_q, upper_q, lower_q;
   ctrl_t ctrl_q;

   assign word_wr   = wr_i && (&be_i) && !clr_i;
   assign ctrl_wr_o = word_wr && (addr_i == ADR_CTRL);
   assign trig_o    = ctrl_wr_o && wdata_i[CTL_TRIG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= '0;
         upper_q <= UPPER_RST;
         lower_q <= LOWER_RST;
         ctrl_q  <= '0;
      end else if (clr_i) begin
         err_q   <= '0;
         upper_q <= UPPER_RST;
         lower_q <= LOWER_RST;
         ctrl_q  <= '0;
      end else begin
         if (smp_vld_i)
            err_q <= smp_err_i;
         else if (word_wr && addr_i == ADR_ERR)
            err_q <= wdata_i;
         if (word_wr && addr_i == ADR_UPPER) upper_q <= wdata_i;
         if (word_wr && addr_i == ADR_LOWER) lower_q <= wdata_i;
         if (ctrl_wr_o) ctrl_q <= ctrl_t'(wdata_i[CTL_W-1:0]);
      end
   end

   always_comb begin
      unique case (reg_adr_e'(addr_i))
         ADR_ERR:  rdata_o = err_q;
         ADR_CTRL: rdata_o = {{(ERR_W-CTL_W){1'b0}}, ctrl_q};
         default:  rdata_o = '0;
      endcase
   end

   assign err_q_o   = err_q;
   assign upper_q_o = upper_q;
   assign lower_q_o = lower_q;
   assign ctrl_q_o  = ctrl_q;
endmodule

// File: rtl/spd_lock_win.sv
module spd_lock_win #(
   parameter int ERR_W    = 16,
   parameter bit LIMIT_HW = 1'b1
) (
   input  logic signed [ERR_W-1:0] val_i,
   input  logic signed [ERR_W-1:0] upper_i,
   input  logic signed [ERR_W-1:0] lower_i,
   input  logic                    lim_en_i,
   output logic                    in_rng_o,
   output logic signed [ERR_W-1:0] lim_o
);
   logic above, below;

   assign above    = val_i > upper_i;
   assign below    = val_i < lower_i;
   assign in_rng_o = !above && !below;

   generate
      if (LIMIT_HW) begin : g_lim
         always_comb begin
            if (lim_en_i && above)      lim_o = upper_i;
            else if (lim_en_i && below) lim_o = lower_i;
            else                        lim_o = val_i;
         end
      end else begin : g_pass
         assign lim_o = val_i;
      end
   endgenerate
endmodule

// File: rtl/spd_lock_cnt.sv
module spd_lock_cnt #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             restart_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             hit_i,
   input  logic             miss_i,
   output logic             lock_o
);
   localparam int CNT_W = 1 << SEL_W;

   logic [CNT_W-1:0] cnt_q, reload;
   logic             lock_q;

   assign reload = CNT_W'(1) << sel_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(1);
         lock_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q  <= CNT_W'(1);
         lock_q <= 1'b0;
      end else if (restart_i || miss_i) begin
         cnt_q  <= reload;
         lock_q <= 1'b0;
      end else if (hit_i) begin
         if (cnt_q > CNT_W'(1)) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end else begin
            cnt_q  <= '0;
            lock_q <= 1'b1;
         end
      end
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/spd_lock_limiter.sv
module spd_lock_limiter
   import spd_lock_pkg::*;
#(
   parameter int ERR_W    = 16,
   parameter bit LIMIT_HW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby_i,
   input  logic             mstop_i,
   input  logic             err_vld_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic             reg_wr_i,
   input  logic [ERR_W/8-1:0] reg_be_i,
   input  logic [1:0]       reg_addr_i,
   input  logic [ERR_W-1:0] reg_wdata_i,
   output logic [ERR_W-1:0] reg_rdata_o,
   output logic [ERR_W-1:0] flt_err_o,
   output logic             flt_vld_o,
   output logic             lock_o
);
   generate
      if (ERR_W < 8 || (ERR_W % 8) != 0) begin : g_bad_w
         $error("spd_lock_limiter: ERR_W must be a multiple of 8");
      end
      if (ERR_W < $bits(ctrl_t) + 3) begin : g_bad_ctl
         $error("spd_lock_limiter: ERR_W too narrow for control fields");
      end
   endgenerate

   logic             clr;
   logic [ERR_W-1:0] err_q, upper_q, lower_q;
   ctrl_t            ctrl_q;
   logic             ctrl_wr, trig;
   logic             smp_in_rng, reg_in_rng;
   logic [ERR_W-1:0] smp_lim, reg_lim;
   logic             auto_vld, restart;
   logic [SEL_W-1:0] cnt_sel;
   logic [ERR_W-1:0] flt_err_q;
   logic             flt_vld_q;

   assign clr = standby_i || mstop_i;

   spd_lock_regs #(.ERR_W(ERR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .smp_vld_i (err_vld_i),
      .smp_err_i (err_i),
      .wr_i      (reg_wr_i),
      .be_i      (reg_be_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .rdata_o   (reg_rdata_o),
      .err_q_o   (err_q),
      .upper_q_o (upper_q),
      .lower_q_o (lower_q),
      .ctrl_q_o  (ctrl_q),
      .ctrl_wr_o (ctrl_wr),
      .trig_o    (trig)
   );

   spd_lock_win #(.ERR_W(ERR_W), .LIMIT_HW(LIMIT_HW)) u_win_smp (
      .val_i    (err_i),
      .upper_i  (upper_q),
      .lower_i  (lower_q),
      .lim_en_i (ctrl_q.lim_en),
      .in_rng_o (smp_in_rng),
      .lim_o    (smp_lim)
   );

   spd_lock_win #(.ERR_W(ERR_W), .LIMIT_HW(LIMIT_HW)) u_win_reg (
      .val_i    (err_q),
      .upper_i  (upper_q),
      .lower_i  (lower_q),
      .lim_en_i (ctrl_q.lim_en),
      .in_rng_o (reg_in_rng),
      .lim_o    (reg_lim)
   );

   assign restart = ctrl_wr || !ctrl_q.lock_en;
   assign cnt_sel = ctrl_wr ? reg_wdata_i[CTL_SEL_LSB +: SEL_W] : ctrl_q.sel;

   spd_lock_cnt #(.SEL_W(SEL_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .restart_i (restart),
      .sel_i     (cnt_sel),
      .hit_i     (err_vld_i && smp_in_rng),
      .miss_i    (err_vld_i && !smp_in_rng),
      .lock_o    (lock_o)
   );

   assign auto_vld = err_vld_i && ctrl_q.auto_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_vld_q <= 1'b0;
         flt_err_q <= '0;
      end else if (clr) begin
         flt_vld_q <= 1'b0;
         flt_err_q <= '0;
      end else begin
         flt_vld_q <= auto_vld || trig;
         if (auto_vld)  flt_err_q <= smp_lim;
         else if (trig) flt_err_q <= reg_lim;
      end
   end

   assign flt_err_o = flt_err_q;
   assign flt_vld_o = flt_vld_q;
endmodule

// File: rtl/spd_lock_chk.sv
module spd_lock_chk #(
   parameter int ERR_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr_i,
   input logic                    err_vld_i,
   input logic                    auto_x,
   input logic                    lim_en,
   input logic                    lock_en,
   input logic                    trig,
   input logic signed [ERR_W-1:0] upper_q,
   input logic signed [ERR_W-1:0] lower_q,
   input logic signed [ERR_W-1:0] flt_err_o,
   input logic                    flt_vld_o,
   input logic                    lock_o
);
   AST_LOCK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> lock_en);  // R9
   AST_AUTO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld_i && auto_x && !clr_i) |=> flt_vld_o);  // R6
   AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      flt_vld_o |-> ($past(err_vld_i && auto_x) || $past(trig)));  // R7
   AST_OUT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_vld_o && $past(lim_en) && ($past(lower_q) <= $past(upper_q)))
      |-> (flt_err_o <= $past(upper_q) && flt_err_o >= $past(lower_q)));  // R5
   AST_LOCK_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(err_vld_i));  // R8
   AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i) |-> (!lock_o && !flt_vld_o));  // R1
endmodule

bind spd_lock_limiter spd_lock_chk #(.ERR_W(ERR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr),
   .err_vld_i (err_vld_i),
   .auto_x    (ctrl_q.auto_x),
   .lim_en    (ctrl_q.lim_en),
   .lock_en   (ctrl_q.lock_en),
   .trig      (trig),
   .upper_q   (upper_q),
   .lower_q   (lower_q),
   .flt_err_o (flt_err_o),
   .flt_vld_o (flt_vld_o),
   .lock_o    (lock_o)
);

// File: tb/spd_lock_limiter_tb.sv
module spd_lock_limiter_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic standby_i = 0, mstop_i = 0, err_vld_i = 0, reg_wr_i = 0;
   logic [15:0] err_i = '0, reg_wdata_i = '0;
   logic [1:0]  reg_be_i = '0, reg_addr_i = '0;
   logic [15:0] reg_rdata_o, flt_err_o;
   logic        flt_vld_o, lock_o;

   int n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spd_lock_limiter u_dut (
      .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .mstop_i(mstop_i),
      .err_vld_i(err_vld_i), .err_i(err_i), .reg_wr_i(reg_wr_i),
      .reg_be_i(reg_be_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .flt_err_o(flt_err_o),
      .flt_vld_o(flt_vld_o), .lock_o(lock_o)
   );

   // reference state built from the requirements
   logic signed [15:0] m_err, m_up, m_lo;
   logic [4:0] m_ctl;
   int m_cnt;
   logic m_lock;

   task automatic m_reset();
      m_err = 16'h0000; m_up = 16'h7FFF; m_lo = 16'h8000;
      m_ctl = '0; m_cnt = 1; m_lock = 1'b0;
   endtask

   function automatic logic signed [15:0] f_lim(logic signed [15:0] e);
      if (m_ctl[1] && e > m_up) return m_up;
      if (m_ctl[1] && e < m_lo) return m_lo;
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock of stimulus, model update and port checks
   task automatic do_op(input bit vld, input logic [15:0] e, input bit wr,
                        input logic [1:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit clr);
      bit word, cw, trig, ev;
      logic signed [15:0] eo;
      word = wr && be == 2'b11;
      cw = word && a == 2'd3;
      trig = cw && d[7];
      ev = 0; eo = '0;
      err_vld_i = vld; err_i = e; reg_wr_i = wr; reg_addr_i = a;
      reg_wdata_i = d; reg_be_i = be; standby_i = clr; mstop_i = 1'b0;
      if (clr) begin
         m_reset();
      end else begin
         if (vld && m_ctl[2]) begin ev = 1; eo = f_lim(e); end
         else if (trig) begin ev = 1; eo = f_lim(m_err); end
         if (cw) begin m_cnt = 1 << d[4:3]; m_lock = 0; end
         else if (!m_ctl[0]) begin m_cnt = 1 << m_ctl[4:3]; m_lock = 0; end
         else if (vld) begin
            if ($signed(e) >= m_lo && $signed(e) <= m_up) begin
               if (m_cnt > 1) m_cnt--; else begin m_cnt = 0; m_lock = 1; end
            end else begin m_cnt = 1 << m_ctl[4:3]; m_lock = 0; end
         end
         if (vld) m_err = e; else if (word && a == 2'd0) m_err = d;
         if (word && a == 2'd1) m_up = d;
         if (word && a == 2'd2) m_lo = d;
         if (cw) m_ctl = d[4:0];
      end
      @(posedge clk);
      @(negedge clk);
      err_vld_i = 0; reg_wr_i = 0; standby_i = 0; reg_be_i = 2'b00;
      chk(flt_vld_o == ev, "R6/R7 strobe", flt_vld_o, ev);
      if (ev) chk(flt_err_o == eo, "R5 limited value", flt_err_o, eo);
      chk(lock_o == m_lock, "R8/R9 lock", lock_o, m_lock);
      reg_addr_i = 2'd0; #1;
      chk(reg_rdata_o == m_err, "R2 error readback", reg_rdata_o, m_err);
      reg_addr_i = 2'd3; #1;
      chk(reg_rdata_o == {11'd0, m_ctl}, "R10 control readback", reg_rdata_o, m_ctl);
   endtask

   task automatic smp(input logic [15:0] e);
      do_op(1, e, 0, 2'd0, 16'd0, 2'b00, 0);
   endtask
   task automatic wrr(input logic [1:0] a, input logic [15:0] d);
      do_op(0, 16'd0, 1, a, d, 2'b11, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(lock_o == 0 && flt_vld_o == 0, "R1 reset outputs", {lock_o, flt_vld_o}, 0);
      reg_addr_i = 2'd0; #1; chk(reg_rdata_o == 0, "R1 error reset", reg_rdata_o, 0);
      reg_addr_i = 2'd1; #1; chk(reg_rdata_o == 0, "R4 upper reads zero", reg_rdata_o, 0);
      reg_addr_i = 2'd2; #1; chk(reg_rdata_o == 0, "R4 lower reads zero", reg_rdata_o, 0);
      // R1 reset bounds: limiter on, extremes pass
      wrr(2'd3, 16'h0006);
      smp(16'h7FFF); smp(16'h8000);
      // window +/-100, lock enabled, limiter, auto, select 10 (4 hits)
      wrr(2'd1, 16'd100); wrr(2'd2, -16'sd100);
      reg_addr_i = 2'd1; #1; chk(reg_rdata_o == 0, "R4 upper write-only", reg_rdata_o, 0);
      wrr(2'd3, 16'h0017);
      smp(16'd50); smp(-16'sd100); smp(16'd100);
      chk(lock_o == 0, "R8 no lock after 3 of 4", lock_o, 0);
      smp(16'd0);
      chk(lock_o == 1, "R8 lock after 4 hits", lock_o, 1);
      smp(16'd101);   // R9 out of range drops lock, R5 clamp to upper
      smp(-16'sd300); // R5 clamp to lower
      // R3 byte write ignored
      do_op(0, 16'd0, 1, 2'd1, 16'd5, 2'b01, 0);
      do_op(0, 16'd0, 1, 2'd3, 16'h0000, 2'b10, 0);
      smp(16'd200);
      // R7 software trigger with auto off
      wrr(2'd3, 16'h001B);
      wrr(2'd0, 16'h1234);
      smp(16'd7);  // R6 no strobe with auto off
      wrr(2'd0, 16'h1234);
      wrr(2'd3, 16'h009B);  // trigger: 0x1234 limited to 100
      // R8 select 11: 8 hits
      wrr(2'd3, 16'h001D);
      for (int i = 0; i < 8; i++) smp(16'(i * 10));
      chk(lock_o == 1, "R8 lock after 8 hits", lock_o, 1);
      wrr(2'd3, 16'h001D);  // R9 control write restarts
      chk(lock_o == 0, "R9 control write clears lock", lock_o, 0);
      // R1 standby and module stop clear
      do_op(1, 16'd3, 0, 2'd0, 16'd0, 2'b00, 1);
      mstop_i = 1'b1; @(posedge clk); @(negedge clk); mstop_i = 1'b0;
      chk(lock_o == 0 && flt_vld_o == 0, "R1 mstop clear", {lock_o, flt_vld_o}, 0);
      // random phase
      for (int k = 0; k < 3000; k++) begin
         int kind;
         logic [15:0] e;
         kind = $urandom_range(0, 19);
         e = 16'($signed($urandom_range(0, 500)) - 250);
         if ($urandom_range(0, 30) == 0) e = ($urandom_range(0, 1) != 0) ? 16'h7FFF : 16'h8000;
         if (kind < 12) smp(e);
         else if (kind < 14)
            wrr(2'd1, 16'($signed($urandom_range(0, 250)) - 50));
         else if (kind < 16)
            wrr(2'd2, 16'($signed($urandom_range(0, 250)) - 200));
         else if (kind < 18)
            wrr(2'd3, {8'd0, ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0, 2'b00,
                       5'($urandom_range(0, 31)) | 5'b00001});
         else if (kind == 18)
            do_op($urandom_range(0, 1) != 0, e, 1, 2'($urandom_range(0, 3)),
                  16'($urandom_range(0, 65535)), 2'($urandom_range(0, 3)), 0);
         else
            do_op(0, 16'd0, 0, 2'd0, 16'd0, 2'b00, $urandom_range(0, 9) == 0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule